// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a small synchronous static RAM whose data bus never needs an idle cycle between a read and a write. Commands (address, byte write strobes, read/write select, three chip selects and a burst-advance flag) are captured on the rising clock edge. Write data is accepted late, after its address. This lets a write's data slot sit in the bus cycle after the preceding read's output slot, so reads and writes can alternate on every clock.

A static `flowMode` input chooses between two timings. In registered-output mode, read data passes through an output register and write data comes two edges after its address. In flow-through mode, read data leaves combinationally from the array in the cycle after the command, and write data comes one edge after its address. A write that has been issued but not yet committed is forwarded to a read of the same word, with its byte strobes merged in. Four-beat bursts run in linear or interleaved order. An asynchronous output enable and an asynchronous sleep input both silence the outputs at once. The bidirectional data bus is split into `dataIn`, `dataOut` and `dataOe`.

Top module: `zbtSram`

## Requirements
- R1: Command inputs are sampled on the rising edge. Write data is sampled 2 edges after its command when `flowMode`=0, and 1 edge after when `flowMode`=1.
- R2: With `flowMode`=0, a read sampled at edge n drives its word (with `dataOe`=1) during the period between edges n+1 and n+2.
- R3: With `flowMode`=1, a read sampled at edge n drives its word during the period between edges n and n+1.
- R4: Reads and writes may be issued on consecutive edges in any mix with no idle cycle. A write's data slot never has `dataOe` high.
- R5: Data bits [9b+8:9b] form byte b, and that byte is written only when `byteWrN[b]`=0. Other bytes keep their stored value.
- R6: A new command is accepted only when `selLowA`=0, `selHigh`=1 and `selLowB`=0 with `advance`=0. Otherwise the edge is idle and later produces no output. A burst continuation (`advance`=1) ignores the chip selects.
- R7: With `interleave`=0, burst beat k (k=0..3, counted modulo 4) addresses the upper address bits of the start address, with low two bits equal to (start low bits + k) mod 4.
- R8: With `interleave`=1, burst beat k uses low two bits equal to (start low bits XOR k). Each beat's read/write type comes from the starting command, and each write beat takes the byte strobes sampled on its own edge.
- R9: `outEnN`=1 forces `dataOe`=0 and `dataOut`=0 immediately, whatever commands are pending.
- R10: While `sleep`=1, `dataOe` is 0, new commands and burst continuations are ignored (an active burst ends), and stored contents are kept.
- R11: A read issued right after a write to the same word returns the written bytes merged with the stored ones, before the write reaches the array.
- R12: While `rstN`=0 and after reset, `dataOe` is 0 until a read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| flowMode | input | 1 | Static: 1 flow-through, 0 registered output |
| interleave | input | 1 | Static: 1 interleaved burst order, 0 linear |
| selLowA | input | 1 | Chip select, active low |
| selHigh | input | 1 | Chip select, active high |
| selLowB | input | 1 | Chip select, active low |
| advance | input | 1 | 1 continues the current burst with the next beat |
| writeN | input | 1 | 0 write command, 1 read command |
| byteWrN | input | BYTES | Per-byte write strobes, active low |
| addr | input | ADDR_W | Word address |
| dataIn | input | BYTES*BYTE_W | Write data (bus input side) |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down request |
| dataOut | output | BYTES*BYTE_W | Read data (bus output side), 0 when not driving |
| dataOe | output | 1 | Bus driver enable |

## Verification
Several properties are checked on every clock edge from the port timing alone. Any freshly accepted read must drive the bus in its mode's slot. A fresh write or an idle edge must leave its slot undriven. `outEnN`, `sleep` and reset must keep the drivers off. The correctness of returned words is left to the bench scenarios: byte merging, forwarding of uncommitted writes, burst address sequences in both orders, and the effect of deselected or sleeping commands on memory. The bench runs all four mode combinations against an arithmetic reference memory.

// File: rtl/zbtSramPkg.sv
package zbtSramPkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmdKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rdValid;   // stage holding a read is being accessed this cycle
    logic wrCommit;  // a write commits on the coming edge using dataIn
    logic pipeOut;   // output register in use
  } dpCtrl_t;

endpackage

// File: rtl/zbtSramCtrl.sv
module zbtSramCtrl
  import zbtSramPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowMode,
  input  logic              interleave,
  input  logic              selLowA,
  input  logic              selHigh,
  input  logic              selLowB,
  input  logic              advance,
  input  logic              writeN,
  input  logic [BYTES-1:0]  byteWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sleep,
  output dpCtrl_t           strobes,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTES-1:0]  wrBe
);

  localparam int HIGH_W = ADDR_W - BURST_W;

  typedef struct packed {
    cmdKind_t          kind;
    logic [ADDR_W-1:0] addr;
    logic [BYTES-1:0]  be;
  } stage_t;

  stage_t issued, stage0, stage1, commitStage;

  logic               burstOn, burstWr;
  logic [ADDR_W-1:0]  burstBase;
  logic [BURST_W-1:0] beatCnt, nextCnt, beatLow;
  logic               chipOn, takeBeat, takeNew;

  assign chipOn   = !selLowA && selHigh && !selLowB;
  assign takeBeat = !sleep && advance && burstOn;
  assign takeNew  = !sleep && !advance && chipOn;
  assign nextCnt  = beatCnt + 1'b1;

  always_comb begin
    if (interleave) beatLow = burstBase[BURST_W-1:0] ^ nextCnt;
    else            beatLow = burstBase[BURST_W-1:0] + nextCnt;
  end

  always_comb begin
    issued.kind = CMD_IDLE;
    issued.addr = '0;
    issued.be   = '0;
    if (takeBeat) begin
      issued.kind = burstWr ? CMD_WRITE : CMD_READ;
      issued.addr = {burstBase[ADDR_W-1 -: HIGH_W], beatLow};
      issued.be   = burstWr ? ~byteWrN : '0;
    end else if (takeNew) begin
      issued.kind = writeN ? CMD_READ : CMD_WRITE;
      issued.addr = addr;
      issued.be   = writeN ? '0 : ~byteWrN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage0.kind <= CMD_IDLE;
      stage0.addr <= '0;
      stage0.be   <= '0;
      stage1.kind <= CMD_IDLE;
      stage1.addr <= '0;
      stage1.be   <= '0;
      burstOn     <= 1'b0;
      burstWr     <= 1'b0;
      burstBase   <= '0;
      beatCnt     <= '0;
    end else begin
      stage0 <= issued;
      stage1 <= stage0;
      if (takeBeat) begin
        beatCnt <= nextCnt;
      end else if (takeNew) begin
        burstOn   <= 1'b1;
        burstWr   <= !writeN;
        burstBase <= addr;
        beatCnt   <= '0;
      end else begin
        burstOn <= 1'b0;
      end
    end
  end

  // late write: one stage deep when flow-through, two when registered
  assign commitStage = flowMode ? stage0 : stage1;

  assign strobes.rdValid  = (stage0.kind == CMD_READ);
  assign strobes.wrCommit = (commitStage.kind == CMD_WRITE);
  assign strobes.pipeOut  = !flowMode;
  assign rdAddr = stage0.addr;
  assign wrAddr = commitStage.addr;
  assign wrBe   = commitStage.be;

endmodule

// File: rtl/zbtSramData.sv
module zbtSramData
  import zbtSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtrl_t                 strobes,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [BYTES-1:0]        wrBe,
  input  logic [BYTES*BYTE_W-1:0] dataIn,
  input  logic                    outEnN,
  input  logic                    sleep,
  output logic [BYTES*BYTE_W-1:0] dataOut,
  output logic                    dataOe
);

  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] arrayWord, mergedWord, outReg, readyWord;
  logic              outValid, readyValid, fwdHit;

  always_ff @(posedge clk) begin
    if (strobes.wrCommit) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wrBe[b]) mem[wrAddr][b*BYTE_W +: BYTE_W] <= dataIn[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign arrayWord = mem[rdAddr];
  assign fwdHit    = strobes.wrCommit && (wrAddr == rdAddr);

  for (genvar b = 0; b < BYTES; b++) begin : gMerge
    assign mergedWord[b*BYTE_W +: BYTE_W] = (fwdHit && wrBe[b]) ?
        dataIn[b*BYTE_W +: BYTE_W] : arrayWord[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      outValid <= 1'b0;
    end else begin
      outReg   <= mergedWord;
      outValid <= strobes.pipeOut && strobes.rdValid;
    end
  end

  assign readyWord  = strobes.pipeOut ? outReg : mergedWord;
  assign readyValid = strobes.pipeOut ? outValid : strobes.rdValid;
  assign dataOe     = readyValid && !outEnN && !sleep;
  assign dataOut    = dataOe ? readyWord : '0;

endmodule

// File: rtl/zbtSram.sv
module zbtSram
  import zbtSramPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTES   = 2,
  parameter int BYTE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flowMode,
  input  logic                    interleave,
  input  logic                    selLowA,
  input  logic                    selHigh,
  input  logic                    selLowB,
  input  logic                    advance,
  input  logic                    writeN,
  input  logic [BYTES-1:0]        byteWrN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] dataIn,
  input  logic                    outEnN,
  input  logic                    sleep,
  output logic [BYTES*BYTE_W-1:0] dataOut,
  output logic                    dataOe
);

  dpCtrl_t           strobes;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [BYTES-1:0]  wrBe;

  zbtSramCtrl #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BURST_W(BURST_W)) ctrl (
    .clk(clk), .rstN(rstN), .flowMode(flowMode), .interleave(interleave),
    .selLowA(selLowA), .selHigh(selHigh), .selLowB(selLowB),
    .advance(advance), .writeN(writeN), .byteWrN(byteWrN), .addr(addr),
    .sleep(sleep), .strobes(strobes), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrBe(wrBe)
  );

  zbtSramData #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdAddr(rdAddr),
    .wrAddr(wrAddr), .wrBe(wrBe), .dataIn(dataIn), .outEnN(outEnN),
    .sleep(sleep), .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: rtl/zbtSramChk.sv
module zbtSramChk (
  input logic clk,
  input logic rstN,
  input logic flowMode,
  input logic selLowA,
  input logic selHigh,
  input logic selLowB,
  input logic advance,
  input logic writeN,
  input logic outEnN,
  input logic sleep,
  input logic dataOe
);

  logic [1:0] warm;
  logic       warmOk, chipOn, newRd, newWr, noCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= 2'd0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  assign warmOk = (warm >= 2'd2);
  assign chipOn = !selLowA && selHigh && !selLowB;
  assign newRd  = !sleep && !advance && chipOn && writeN;
  assign newWr  = !sleep && !advance && chipOn && !writeN;
  assign noCmd  = !advance && (!chipOn || sleep);

  // R2
  pipe_read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warmOk && !flowMode && $past(newRd, 2) && !outEnN && !sleep) |-> dataOe);

  // R3
  flow_read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warmOk && flowMode && $past(newRd) && !outEnN && !sleep) |-> dataOe);

  // R4
  pipe_write_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warmOk && !flowMode && $past(newWr, 2)) |-> !dataOe);

  // R4
  flow_write_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warmOk && flowMode && $past(newWr)) |-> !dataOe);

  // R6
  pipe_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warmOk && !flowMode && $past(noCmd, 2)) |-> !dataOe);

  // R6
  flow_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warmOk && flowMode && $past(noCmd)) |-> !dataOe);

  // R9
  oe_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataOe);

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dataOe);

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> !dataOe);

endmodule

bind zbtSram zbtSramChk chkInst (
  .clk(clk), .rstN(rstN), .flowMode(flowMode), .selLowA(selLowA),
  .selHigh(selHigh), .selLowB(selLowB), .advance(advance), .writeN(writeN),
  .outEnN(outEnN), .sleep(sleep), .dataOe(dataOe)
);

// File: tb/zbtSram_test.sv
module zbtSram_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int BYTES  = 2;
  localparam int BYTE_W = 9;
  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SLOTS  = 256;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, flowMode, interleave, selLowA, selHigh, selLowB, advance, writeN;
  logic outEnN, sleep, dataOe;
  logic [BYTES-1:0]  byteWrN;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataIn, dataOut;

  zbtSram #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) uut (
    .clk(clk), .rstN(rstN), .flowMode(flowMode), .interleave(interleave),
    .selLowA(selLowA), .selHigh(selHigh), .selLowB(selLowB),
    .advance(advance), .writeN(writeN), .byteWrN(byteWrN), .addr(addr),
    .dataIn(dataIn), .outEnN(outEnN), .sleep(sleep), .dataOut(dataOut),
    .dataOe(dataOe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] refMem [DEPTH];
  logic [DATA_W-1:0] wSched [SLOTS];
  logic [DATA_W-1:0] expD   [SLOTS];
  logic              expV   [SLOTS];
  bit  bActive, bWrite;
  int  bBase, bCnt;
  logic [31:0] lfsr = 32'h1d2c3b4a;

  function automatic logic [DATA_W-1:0] junk(input int k);
    return DATA_W'((k * 1237 + 91) ^ (k << 5));
  endfunction

  function automatic logic [DATA_W-1:0] pat(input int k);
    return DATA_W'(k * 2731 + 17);
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic checkSlot(input string tag);
    int s;
    logic expOe;
    logic [DATA_W-1:0] expOut;
    s = cyc % SLOTS;
    expOe  = expV[s] && !outEnN && !sleep && rstN;
    expOut = expOe ? expD[s] : '0;
    checks++;
    if (dataOe !== expOe || dataOut !== expOut) begin
      fails++;
      $display("FAIL %s cycle %0d: oe=%b data=%h expected oe=%b data=%h",
               tag, cyc, dataOe, dataOut, expOe, expOut);
    end
    expV[s] = 1'b0;
  endtask

  // one clock of stimulus; the reference decides what the edge does
  task automatic step(input logic sa, input logic sh, input logic sb,
                      input logic adv, input logic wn,
                      input logic [BYTES-1:0] bwn, input int a,
                      input logic [DATA_W-1:0] wd, input logic oen,
                      input logic slp, input string tag);
    int lw, lr, ea, s;
    logic isW, isR;
    logic [BYTES-1:0] be;
    @(negedge clk);
    lw = flowMode ? 1 : 2;
    lr = flowMode ? 0 : 1;
    isW = 1'b0; isR = 1'b0; ea = 0;
    if (!slp && adv && bActive) begin
      bCnt = (bCnt + 1) % 4;
      ea = (bBase & ~3) | (interleave ? ((bBase & 3) ^ bCnt) : (((bBase & 3) + bCnt) % 4));
      isW = bWrite; isR = !bWrite;
    end else if (!slp && !adv && !sa && sh && !sb) begin
      bActive = 1'b1; bBase = a; bCnt = 0; bWrite = !wn;
      ea = a; isW = !wn; isR = wn;
    end else begin
      bActive = 1'b0;
    end
    be = ~bwn;
    if (isW) begin
      for (int b = 0; b < BYTES; b++)
        if (be[b]) refMem[ea][b*BYTE_W +: BYTE_W] = wd[b*BYTE_W +: BYTE_W];
      wSched[(cyc + lw) % SLOTS] = wd;
    end
    if (isR) begin
      s = (cyc + 1 + lr) % SLOTS;
      expV[s] = 1'b1;
      expD[s] = refMem[ea];
    end
    selLowA = sa; selHigh = sh; selLowB = sb; advance = adv; writeN = wn;
    byteWrN = bwn; addr = ADDR_W'(a); outEnN = oen; sleep = slp;
    dataIn = wSched[cyc % SLOTS];
    wSched[cyc % SLOTS] = junk(cyc);
    #1;
    checkSlot(tag);
  endtask

  task automatic doWrite(input int a, input logic [DATA_W-1:0] d,
                         input logic [BYTES-1:0] bwn, input string tag);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, bwn, a, d, 1'b0, 1'b0, tag);
  endtask

  task automatic doRead(input int a, input string tag);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, a, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic doAdv(input logic [DATA_W-1:0] d, input string tag);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 0, d, 1'b0, 1'b0, tag);
  endtask

  task automatic doIdle(input string tag);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; selLowA = 1'b1; selHigh = 1'b0; selLowB = 1'b1;
    advance = 1'b0; writeN = 1'b1; byteWrN = '1; addr = '0;
    dataIn = '0; outEnN = 1'b0; sleep = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin expV[i] = 1'b0; wSched[i] = junk(i + 7); end
    bActive = 1'b0; bCnt = 0; bBase = 0; bWrite = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      checkSlot("R12 in reset");
    end
    rstN = 1'b1;
    #1;
    checkSlot("R12 after reset");
  endtask

  task automatic runConfig();
    doReset();
    // R1: back-to-back full writes of every word
    for (int a = 0; a < DEPTH; a++) doWrite(a, pat(a + cyc), 2'b00, "R1 fill");
    for (int a = 0; a < DEPTH; a++) doRead(a, flowMode ? "R3 read" : "R2 read");
    // R4: alternating read/write with no gaps
    for (int i = 0; i < 12; i++) begin
      doRead(i, "R4 mix");
      doWrite(i + 20, pat(i * 5 + cyc), 2'b00, "R4 mix");
    end
    for (int i = 0; i < 12; i++) doRead(i + 20, "R4 readback");
    // R11: read right after write, same word, full and partial
    doWrite(40, 18'h2aaaa, 2'b00, "R11");
    doRead(40, "R11 forward full");
    doWrite(40, 18'h15555, 2'b10, "R11");
    doRead(40, "R11 forward byte0");
    doWrite(41, 18'h0f0f0, 2'b01, "R11");
    doRead(41, "R11 forward byte1");
    doIdle("R11"); doIdle("R11");
    doRead(40, "R11 after commit"); doRead(41, "R11 after commit");
    // R5: byte strobes
    doWrite(50, 18'h3ffff, 2'b00, "R5");
    doWrite(50, 18'h00000, 2'b10, "R5");
    doWrite(51, 18'h12345, 2'b00, "R5");
    doWrite(51, 18'h00000, 2'b11, "R5");
    doWrite(52, 18'h1abcd, 2'b01, "R5");
    doIdle("R5"); doIdle("R5");
    doRead(50, "R5 low byte"); doRead(51, "R5 none"); doRead(52, "R5 high byte");
    // R6: each chip select alone blocks a command
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 60, 18'h11111, 1'b0, 1'b0, "R6 selA");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 60, 18'h22222, 1'b0, 1'b0, "R6 selHigh");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 60, 18'h33333, 1'b0, 1'b0, "R6 selB");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 60, '0, 1'b0, 1'b0, "R6 desel read");
    doIdle("R6"); doIdle("R6");
    doRead(60, "R6 unchanged");
    // R7 / R8: bursts from each start offset
    for (int st = 0; st < 4; st++) begin
      doWrite(8 + st, pat(st * 11 + cyc), 2'b00, interleave ? "R8 burst wr" : "R7 burst wr");
      for (int k = 1; k < 4; k++) doAdv(pat(k * 3 + st + cyc), interleave ? "R8 burst wr" : "R7 burst wr");
      doRead(8 + st, interleave ? "R8 burst rd" : "R7 burst rd");
      for (int k = 1; k < 4; k++) doAdv('0, interleave ? "R8 burst rd" : "R7 burst rd");
      for (int k = 0; k < 4; k++) doRead(8 + k, interleave ? "R8 single rd" : "R7 single rd");
    end
    // R9: output enable released and asserted around pending reads
    doRead(3, "R9");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 4, '0, 1'b1, 1'b0, "R9 oe high");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 0, '0, 1'b1, 1'b0, "R9 oe high");
    doIdle("R9"); doIdle("R9");
    // R10: sleep blocks commands and outputs, keeps contents
    doRead(5, "R10");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 5, 18'h00001, 1'b0, 1'b1, "R10 sleep wr");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 6, '0, 1'b0, 1'b1, "R10 sleep rd");
    doIdle("R10"); doIdle("R10");
    doRead(5, "R10 kept"); doRead(6, "R10 kept");
    doRead(12, "R10 burst"); step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 0, '0, 1'b0, 1'b1, "R10 adv asleep");
    doAdv('0, "R10 burst ended"); doIdle("R10"); doIdle("R10");
    // random mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      lfsr = nextRand(lfsr); r = lfsr;
      case (r[2:0])
        3'd0, 3'd1, 3'd2:
          step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, r[4:3], int'(r[10:5]), DATA_W'(r[31:14]),
               r[13:11] == 3'd0, r[12:9] == 4'd0, "R4 random");
        3'd3, 3'd4, 3'd5:
          step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, r[4:3], int'(r[10:5]), DATA_W'(r[31:14]),
               r[13:11] == 3'd0, r[12:9] == 4'd0, "R11 random");
        3'd6:
          step(r[3], r[4], r[5], 1'b1, r[6], r[8:7], 0, DATA_W'(r[31:14]),
               r[13:11] == 3'd0, 1'b0, interleave ? "R8 random" : "R7 random");
        default:
          step(1'b1, r[4], r[5], 1'b0, r[6], r[8:7], int'(r[10:5]), DATA_W'(r[31:14]),
               r[13:11] == 3'd0, 1'b0, "R6 random");
      endcase
    end
    for (int i = 0; i < 4; i++) doIdle("R4 drain");
    for (int a = 0; a < DEPTH; a++) doRead(a, "R5 final sweep");
    for (int i = 0; i < 3; i++) doIdle("R2 drain");
  endtask

  bit finished = 1'b0;

  initial begin
    rstN = 1'b0; flowMode = 1'b0; interleave = 1'b0;
    selLowA = 1'b1; selHigh = 1'b0; selLowB = 1'b1; advance = 1'b0;
    writeN = 1'b1; byteWrN = '1; addr = '0; dataIn = '0;
    outEnN = 1'b0; sleep = 1'b0;
    for (int cfg = 0; cfg < 4; cfg++) begin
      flowMode   = cfg[0];
      interleave = cfg[1];
      runConfig();
    end
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog R1-related run hung: cycles=%0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule